// File: doc/BRIEF.md
# Two-Way Address Translation Buffer with Access Checking

This block maps a 40-bit virtual address onto a 36-bit physical address for 16 KB pages, looking the mapping up in a two-way set-associative buffer of 256 sets. Every lookup returns a hit flag, the translated address and a protection verdict for the kind of access requested (read, write or instruction fetch, from user or supervisor mode), together with the dirty state of the entry that was hit.

When no entry matches, the block stalls its lookup port, asks an outside agent for the page-table entry of the missing page, installs the answer into the chosen way and then replays the stalled lookup, which now hits. A flush input empties the whole buffer in one cycle. The table walk and fault handling live outside the block and are seen only through the refill request/response pair.

Top module: `xlat_tlb`

## Requirements
- R1: The low 14 address bits are the page offset and pass to the physical address unchanged; virtual address bits [21:14] pick the set and bits [39:22] are the tag compared in both ways; a hit without fault returns {physical page number, offset}.
- R2: While not busy, a lookup with req_valid_i high gets rsp_valid_o high and its hit flag, address, fault and dirty outputs in the same cycle.
- R3: A miss reports rsp_hit_o low; from the next cycle busy_o and refill_req_o stay high, refill_vpn_o holds the 26-bit virtual page number, and lookup inputs are ignored until the refill is answered.
- R4: In the cycle refill_valid_i is high during a request the entry is written; in the following cycle the stalled lookup is replayed with rsp_valid_o and rsp_hit_o high, and busy_o drops one cycle later.
- R5: Access kind encoding: 00 read, 01 write, 10 fetch, 11 treated as read. Access field bits: [2] user allowed, [1] writable, [0] executable. A hit faults when writing a non-writable page, fetching from a non-executable page, or accessing from user mode a page without bit [2]; a faulting hit keeps rsp_hit_o high, raises rsp_fault_o and forces the address to zero.
- R6: rsp_dirty_o gives the dirty bit of the hit entry before this access; a non-faulting write hit sets it; refilled entries start clean; a faulting write leaves it clear.
- R7: The refill victim is way 0 if invalid, else way 1 if invalid, else the least-recently-used way of the set.
- R8: Each hit and each refill marks the other way of the set as least recently used.
- R9: flush_i invalidates every entry in one cycle and resets the recency state; a lookup in the flush cycle misses.
- R10: After reset the buffer is empty and the block is idle with busy_o and refill_req_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 40 | Virtual address |
| req_kind_i | input | 2 | Access kind (R5) |
| req_user_i | input | 1 | Access from user mode |
| busy_o | output | 1 | Lookup port stalled |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Translation found |
| rsp_fault_o | output | 1 | Protection violation |
| rsp_dirty_o | output | 1 | Dirty bit of hit entry before access |
| rsp_paddr_o | output | 36 | Physical address |
| refill_req_o | output | 1 | Page-table entry wanted |
| refill_vpn_o | output | 26 | Page number being refilled |
| refill_valid_i | input | 1 | Page-table entry supplied |
| refill_ppn_i | input | 22 | Physical page number to install |
| refill_acc_i | input | 3 | Access field to install |

## Verification
The hardest state to reach is a full set whose recency bit must choose the victim, since that takes two distinct refills into one set followed by a hit on the older entry before a third page conflicts. The stimulus draws addresses from a handful of sets and several tags per set so conflicts, evictions and re-misses occur often, and directed sequences force the exact eviction order, flush during a lookup, and writes to clean, dirty and read-only pages.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_WAIT   = 2'b01,
    ST_REPLAY = 2'b10
  } tlb_state_e;

  localparam int unsigned ACC_W   = 3;
  localparam int unsigned ACC_USR = 2;
  localparam int unsigned ACC_WR  = 1;
  localparam int unsigned ACC_EX  = 0;
endpackage

// File: rtl/tlb_way_array.sv
module tlb_way_array #(
  parameter int unsigned SET_W = 8,
  parameter int unsigned TAG_W = 18,
  parameter int unsigned PPN_W = 22,
  parameter int unsigned ACC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [SET_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [PPN_W-1:0] rd_ppn_o,
  output logic [ACC_W-1:0] rd_acc_o,
  output logic             rd_dirty_o,
  input  logic             wr_en_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic [ACC_W-1:0] wr_acc_i,
  input  logic             dirty_set_i
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PPN_W-1:0] ppn_q [SETS];
  logic [ACC_W-1:0] acc_q [SETS];

  // fill wins over a same-cycle flush
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (flush_i) valid_q <= '0;
      if (wr_en_i) begin
        valid_q[rd_idx_i] <= 1'b1;
        dirty_q[rd_idx_i] <= 1'b0;
      end else if (dirty_set_i) begin
        dirty_q[rd_idx_i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[rd_idx_i] <= wr_tag_i;
      ppn_q[rd_idx_i] <= wr_ppn_i;
      acc_q[rd_idx_i] <= wr_acc_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_ppn_o   = ppn_q[rd_idx_i];
  assign rd_acc_o   = acc_q[rd_idx_i];
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned SET_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [SET_W-1:0] idx_i,
  input  logic             touch_i,
  input  logic             touch_way_i,
  output logic             lru_way_o
);
  localparam int unsigned SETS = 1 << SET_W;
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lru_q <= '0;
    end else if (flush_i) begin
      lru_q <= '0;
    end else if (touch_i) begin
      lru_q[idx_i] <= ~touch_way_i;
    end
  end

  assign lru_way_o = lru_q[idx_i];
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import xlat_pkg::*;
(
  input  logic [1:0]       kind_i,
  input  logic             user_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             fault_o
);
  acc_kind_e kind;
  assign kind = acc_kind_e'(kind_i);

  always_comb begin
    fault_o = 1'b0;
    if (kind == KIND_WRITE && !acc_i[ACC_WR]) fault_o = 1'b1;
    if (kind == KIND_FETCH && !acc_i[ACC_EX]) fault_o = 1'b1;
    if (user_i && !acc_i[ACC_USR])            fault_o = 1'b1;
  end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic [1:0]      req_kind_i,
  input  logic            req_user_i,
  input  logic            hit_i,
  input  logic            refill_valid_i,
  output tlb_state_e      state_o,
  output logic [VA_W-1:0] lat_vaddr_o,
  output logic [1:0]      lat_kind_o,
  output logic            lat_user_o
);
  tlb_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lat_vaddr_o <= '0;
      lat_kind_o  <= '0;
      lat_user_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          lat_vaddr_o <= req_vaddr_i;
          lat_kind_o  <= req_kind_i;
          lat_user_o  <= req_user_i;
          if (!hit_i) state_q <= ST_WAIT;
        end
        ST_WAIT:   if (refill_valid_i) state_q <= ST_REPLAY;
        ST_REPLAY: state_q <= hit_i ? ST_IDLE : ST_WAIT;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W   = 40,
  parameter int unsigned PA_W   = 36,
  parameter int unsigned PAGE_W = 14,
  parameter int unsigned SET_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 req_valid_i,
  input  logic [VA_W-1:0]      req_vaddr_i,
  input  logic [1:0]           req_kind_i,
  input  logic                 req_user_i,
  output logic                 busy_o,
  output logic                 rsp_valid_o,
  output logic                 rsp_hit_o,
  output logic                 rsp_fault_o,
  output logic                 rsp_dirty_o,
  output logic [PA_W-1:0]      rsp_paddr_o,
  output logic                 refill_req_o,
  output logic [VA_W-PAGE_W-1:0] refill_vpn_o,
  input  logic                 refill_valid_i,
  input  logic [PA_W-PAGE_W-1:0] refill_ppn_i,
  input  logic [2:0]           refill_acc_i
);
  localparam int unsigned VPN_W = VA_W - PAGE_W;
  localparam int unsigned PPN_W = PA_W - PAGE_W;
  localparam int unsigned TAG_W = VPN_W - SET_W;
  localparam int unsigned WAYS  = 2;

  tlb_state_e      state;
  logic [VA_W-1:0] lat_vaddr;
  logic [1:0]      lat_kind;
  logic            lat_user;

  logic            idle;
  logic [VA_W-1:0] lk_vaddr;
  logic [1:0]      lk_kind;
  logic            lk_user;
  logic            lk_valid;
  logic [SET_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;

  logic [WAYS-1:0]  rd_valid, rd_dirty, way_hit, way_fill, way_dset;
  logic [TAG_W-1:0] rd_tag [WAYS];
  logic [PPN_W-1:0] rd_ppn [WAYS];
  logic [ACC_W-1:0] rd_acc [WAYS];

  logic hit, hit_way, fault, fill_en, victim, lru_way, sel_dirty;
  logic [PPN_W-1:0] sel_ppn;
  logic [ACC_W-1:0] sel_acc;

  assign idle     = (state == ST_IDLE);
  assign lk_vaddr = idle ? req_vaddr_i : lat_vaddr;
  assign lk_kind  = idle ? req_kind_i  : lat_kind;
  assign lk_user  = idle ? req_user_i  : lat_user;
  assign lk_valid = (idle && req_valid_i) || (state == ST_REPLAY);
  assign lk_idx   = lk_vaddr[PAGE_W +: SET_W];
  assign lk_tag   = lk_vaddr[PAGE_W+SET_W +: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way_array #(
      .SET_W(SET_W), .TAG_W(TAG_W), .PPN_W(PPN_W), .ACC_W(ACC_W)
    ) u_way (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (flush_i),
      .rd_idx_i    (lk_idx),
      .rd_valid_o  (rd_valid[w]),
      .rd_tag_o    (rd_tag[w]),
      .rd_ppn_o    (rd_ppn[w]),
      .rd_acc_o    (rd_acc[w]),
      .rd_dirty_o  (rd_dirty[w]),
      .wr_en_i     (way_fill[w]),
      .wr_tag_i    (lk_tag),
      .wr_ppn_i    (refill_ppn_i),
      .wr_acc_i    (refill_acc_i),
      .dirty_set_i (way_dset[w])
    );
    assign way_hit[w]  = lk_valid && !flush_i && rd_valid[w] && (rd_tag[w] == lk_tag);
    assign way_fill[w] = fill_en && (victim == w[0]);
    assign way_dset[w] = way_hit[w] && !fault && !rd_dirty[w] &&
                         (acc_kind_e'(lk_kind) == KIND_WRITE);
  end

  assign hit       = |way_hit;
  assign hit_way   = way_hit[1];
  assign sel_ppn   = rd_ppn[hit_way];
  assign sel_acc   = rd_acc[hit_way];
  assign sel_dirty = rd_dirty[hit_way];

  tlb_perm u_perm (
    .kind_i  (lk_kind),
    .user_i  (lk_user),
    .acc_i   (sel_acc),
    .fault_o (fault)
  );

  // victim: first invalid way, else recency bit
  assign fill_en = (state == ST_WAIT) && refill_valid_i;
  assign victim  = !rd_valid[0] ? 1'b0 : (!rd_valid[1] ? 1'b1 : lru_way);

  tlb_lru #(.SET_W(SET_W)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .idx_i       (lk_idx),
    .touch_i     (hit || fill_en),
    .touch_way_i (fill_en ? victim : hit_way),
    .lru_way_o   (lru_way)
  );

  tlb_ctrl #(.VA_W(VA_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_vaddr_i    (req_vaddr_i),
    .req_kind_i     (req_kind_i),
    .req_user_i     (req_user_i),
    .hit_i          (hit),
    .refill_valid_i (refill_valid_i),
    .state_o        (state),
    .lat_vaddr_o    (lat_vaddr),
    .lat_kind_o     (lat_kind),
    .lat_user_o     (lat_user)
  );

  assign busy_o       = !idle;
  assign rsp_valid_o  = lk_valid;
  assign rsp_hit_o    = hit;
  assign rsp_fault_o  = hit && fault;
  assign rsp_dirty_o  = hit && sel_dirty;
  assign rsp_paddr_o  = (hit && !fault) ? {sel_ppn, lk_vaddr[PAGE_W-1:0]} : '0;
  assign refill_req_o = (state == ST_WAIT);
  assign refill_vpn_o = lat_vaddr[VA_W-1:PAGE_W];
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int unsigned VA_W   = 40,
  parameter int unsigned PA_W   = 36,
  parameter int unsigned PAGE_W = 14
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   flush_i,
  input logic                   req_valid_i,
  input logic [VA_W-1:0]        req_vaddr_i,
  input logic                   busy_o,
  input logic                   rsp_valid_o,
  input logic                   rsp_hit_o,
  input logic                   rsp_fault_o,
  input logic [PA_W-1:0]        rsp_paddr_o,
  input logic                   refill_req_o,
  input logic [VA_W-PAGE_W-1:0] refill_vpn_o,
  input logic                   refill_valid_i
);
  a_r3_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_req_o |-> busy_o);

  a_r3_vpn_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_req_o && !refill_valid_i |=> refill_req_o && $stable(refill_vpn_o));

  a_r3_miss_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && rsp_valid_o && !rsp_hit_o |=> refill_req_o);

  a_r4_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_req_o && refill_valid_i |=> rsp_valid_o && (rsp_hit_o || flush_i));

  a_r5_fault_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_hit_o && (rsp_paddr_o == '0));

  a_r9_flush_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !rsp_hit_o);

  a_r1_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_valid_i && rsp_hit_o && !rsp_fault_o |->
      rsp_paddr_o[PAGE_W-1:0] == req_vaddr_i[PAGE_W-1:0]);
endmodule

bind xlat_tlb xlat_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flush_i        (flush_i),
  .req_valid_i    (req_valid_i),
  .req_vaddr_i    (req_vaddr_i),
  .busy_o         (busy_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_hit_o      (rsp_hit_o),
  .rsp_fault_o    (rsp_fault_o),
  .rsp_paddr_o    (rsp_paddr_o),
  .refill_req_o   (refill_req_o),
  .refill_vpn_o   (refill_vpn_o),
  .refill_valid_i (refill_valid_i)
);

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [39:0] req_vaddr_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic        req_user_i = 1'b0;
  logic        busy_o, rsp_valid_o, rsp_hit_o, rsp_fault_o, rsp_dirty_o, refill_req_o;
  logic [35:0] rsp_paddr_o;
  logic [25:0] refill_vpn_o;
  logic        refill_valid_i = 1'b0;
  logic [21:0] refill_ppn_i = '0;
  logic [2:0]  refill_acc_i = '0;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xlat_tlb u_dut (.*);

  // reference model
  logic        m_v   [2][256];
  logic        m_d   [2][256];
  logic [17:0] m_tag [2][256];
  logic [21:0] m_ppn [2][256];
  logic [2:0]  m_acc [2][256];
  logic        m_lru [256];

  function automatic logic [21:0] ppn_of(logic [25:0] vpn);
    return vpn[21:0] ^ 22'h2a5c3 ^ {vpn[25:22], 18'h0};
  endfunction
  function automatic logic [2:0] acc_of(logic [25:0] vpn);
    return vpn[10:8];
  endfunction

  task automatic m_flush();
    for (int s = 0; s < 256; s++) begin
      m_v[0][s] = 1'b0; m_v[1][s] = 1'b0; m_lru[s] = 1'b0;
    end
  endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_hit(logic [39:0] va, logic [1:0] kind, logic user, int w, string tag);
    logic [7:0] s;
    logic [2:0] a;
    logic f;
    logic [35:0] pa;
    s = va[21:14];
    a = m_acc[w][s];
    f = (kind == 2'b01 && !a[1]) || (kind == 2'b10 && !a[0]) || (user && !a[2]);
    pa = f ? 36'h0 : {m_ppn[w][s], va[13:0]};
    chk(rsp_valid_o && rsp_hit_o, {tag, " R2 hit"}, {62'h0, rsp_valid_o, rsp_hit_o}, 64'h3);
    chk(rsp_fault_o == f, "R5 fault", rsp_fault_o, f);
    chk(rsp_paddr_o == pa, "R1 paddr", rsp_paddr_o, pa);
    chk(rsp_dirty_o == m_d[w][s], "R6 dirty", rsp_dirty_o, m_d[w][s]);
    m_lru[s] = (w == 0);
    if (kind == 2'b01 && !f) m_d[w][s] = 1'b1;
  endtask

  // one lookup, with refill if it misses
  task automatic access(logic [39:0] va, logic [1:0] kind, logic user, bit do_flush,
                        int wait_n, string tag);
    logic [7:0] s;
    logic [17:0] t;
    int w;
    int vic;
    s = va[21:14];
    t = va[39:22];
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; req_kind_i = kind; req_user_i = user;
    flush_i = do_flush;
    #2;
    chk(!busy_o, "R2 idle", busy_o, 0);
    if (do_flush) m_flush();
    w = -1;
    if (m_v[0][s] && m_tag[0][s] == t) w = 0;
    else if (m_v[1][s] && m_tag[1][s] == t) w = 1;
    if (w >= 0) begin
      check_hit(va, kind, user, w, tag);
      @(negedge clk_i);
      req_valid_i = 1'b0; flush_i = 1'b0;
      return;
    end
    chk(rsp_valid_o && !rsp_hit_o, {tag, " R3 miss"}, {62'h0, rsp_valid_o, rsp_hit_o}, 64'h2);
    @(negedge clk_i);
    flush_i = 1'b0;
    // stray lookup while stalled must be ignored
    req_vaddr_i = {~va[39:22], va[21:0] ^ 22'h15555}; req_kind_i = 2'b01; req_user_i = 1'b1;
    for (int i = 0; i <= wait_n; i++) begin
      #2;
      chk(busy_o && refill_req_o, "R3 stall", {62'h0, busy_o, refill_req_o}, 64'h3);
      chk(refill_vpn_o == va[39:14], "R3 vpn", refill_vpn_o, va[39:14]);
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;
    refill_valid_i = 1'b1; refill_ppn_i = ppn_of(va[39:14]); refill_acc_i = acc_of(va[39:14]);
    vic = !m_v[0][s] ? 0 : (!m_v[1][s] ? 1 : int'(m_lru[s]));
    m_v[vic][s] = 1'b1; m_d[vic][s] = 1'b0; m_tag[vic][s] = t;
    m_ppn[vic][s] = refill_ppn_i; m_acc[vic][s] = refill_acc_i;
    m_lru[s] = (vic == 0);
    @(negedge clk_i);
    refill_valid_i = 1'b0;
    #2;
    chk(busy_o, "R4 busy in replay", busy_o, 1);
    check_hit(va, kind, user, vic, {tag, " R4 replay"});
    @(negedge clk_i);
    #2;
    chk(!busy_o && !refill_req_o, "R4 released", {62'h0, busy_o, refill_req_o}, 0);
  endtask

  function automatic logic [39:0] mk(logic [17:0] t, logic [7:0] s, logic [13:0] off);
    return {t, s, off};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    m_flush();
    for (int s = 0; s < 256; s++) begin m_d[0][s] = 1'b0; m_d[1][s] = 1'b0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    chk(!busy_o && !refill_req_o, "R10 reset idle", {62'h0, busy_o, refill_req_o}, 0);
    chk(!rsp_valid_o, "R10 no rsp", rsp_valid_o, 0);

    // R10: empty after reset, R1 offset/index split
    access(mk(18'h00123, 8'h05, 14'h3a1), 2'b00, 1'b0, 0, 0, "R10 empty");
    access(mk(18'h00123, 8'h05, 14'h0ff), 2'b00, 1'b0, 0, 0, "R1 same page");
    access(mk(18'h00123, 8'h06, 14'h0ff), 2'b00, 1'b0, 0, 2, "R1 other set");

    // R7 R8: eviction order in set 0x40
    access(mk(18'h00701, 8'h40, 14'h1), 2'b00, 1'b0, 0, 1, "R7 fill way0");
    access(mk(18'h00702, 8'h40, 14'h2), 2'b00, 1'b0, 0, 0, "R7 fill way1");
    access(mk(18'h00701, 8'h40, 14'h3), 2'b00, 1'b0, 0, 0, "R8 touch A");
    access(mk(18'h00703, 8'h40, 14'h4), 2'b00, 1'b0, 0, 0, "R7 evict B");
    access(mk(18'h00701, 8'h40, 14'h5), 2'b00, 1'b0, 0, 0, "R8 A kept");
    access(mk(18'h00702, 8'h40, 14'h6), 2'b00, 1'b0, 0, 0, "R8 B gone");
    access(mk(18'h00703, 8'h40, 14'h7), 2'b00, 1'b0, 0, 0, "R8 C gone");

    // R5: acc 010 supervisor writable no exec; acc 101 user exec read-only
    access(mk(18'h00002, 8'h10, 14'h10), 2'b01, 1'b0, 0, 0, "R5 sup write ok");
    access(mk(18'h00002, 8'h10, 14'h11), 2'b01, 1'b1, 0, 0, "R5 user on sup");
    access(mk(18'h00002, 8'h10, 14'h12), 2'b10, 1'b0, 0, 0, "R5 fetch noexec");
    access(mk(18'h00005, 8'h11, 14'h13), 2'b10, 1'b1, 0, 0, "R5 user fetch ok");
    access(mk(18'h00005, 8'h11, 14'h14), 2'b01, 1'b1, 0, 0, "R5 write ro");
    access(mk(18'h00005, 8'h11, 14'h15), 2'b11, 1'b1, 0, 0, "R5 kind 11 read");

    // R6: dirty on clean/dirty/read-only pages
    access(mk(18'h00006, 8'h20, 14'h1), 2'b00, 1'b0, 0, 0, "R6 fill clean");
    access(mk(18'h00006, 8'h20, 14'h2), 2'b01, 1'b0, 0, 0, "R6 first write");
    access(mk(18'h00006, 8'h20, 14'h3), 2'b01, 1'b0, 0, 0, "R6 second write");
    access(mk(18'h00005, 8'h11, 14'h16), 2'b00, 1'b0, 0, 0, "R6 ro stays clean");

    // R9: flush in lookup cycle, then other pages gone
    access(mk(18'h00006, 8'h20, 14'h4), 2'b00, 1'b0, 1, 0, "R9 flush same cycle");
    access(mk(18'h00701, 8'h40, 14'h5), 2'b00, 1'b0, 0, 0, "R9 after flush");
    access(mk(18'h00002, 8'h10, 14'h5), 2'b00, 1'b0, 0, 0, "R9 after flush 2");

    // random mix over a few conflicting sets
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 500; i++) begin
      logic [7:0] s;
      logic [17:0] t;
      logic [1:0] k;
      case ($urandom % 3)
        0: s = 8'h03; 1: s = 8'h7e; default: s = 8'hc8;
      endcase
      t = 18'($urandom % 6) | (18'($urandom % 2) << 12);
      k = 2'($urandom % 4);
      access(mk(t, s, 14'($urandom)), k, 1'($urandom), ($urandom % 40) == 0,
             int'($urandom % 4), "R2 random");
    end
    finish_run();
  end
endmodule